// File: doc/BRIEF.md
# DS2 Loss-of-Frame Integrator with Alarm Insertion Control

This block watches the out-of-frame flag of every DS2 tributary in a DS3 demultiplexer and turns it into a slower, debounced loss-of-frame flag. Each tributary has its own integration counter. The counter advances once per DS3 frame period, marked by a single-cycle tick. It restarts whenever the out-of-frame level matches the current loss-of-frame state. Loss of frame is declared after 28 consecutive frame periods of out-of-frame. It is withdrawn only after 28 consecutive frame periods in frame. At the usual DS3 rate this is roughly 3 ms each way.

Two provisioning bits decide when the downstream path should replace a tributary's data with an all-ones alarm signal. One bit requests insertion while out-of-frame is active. The other requests it while loss of frame is active. The per-tributary request is the OR of the enabled conditions. The all-ones generator and the frame tick source sit outside this block.

The tributary count, the window length and the request timing are parameters. The request can be combinational or registered. The default is combinational.

Top module: `ds2_lof_integrator`

## Requirements
- R1: After reset every lof_o bit is 0, and with both enables at 0 every ais_req_o bit is 0.
- R2: lof_o[n] goes from 0 to 1 in the cycle after the clock edge that samples the 28th consecutive frame tick at which oof_i[n] is 1, provided oof_i[n] stayed 1 in every cycle of that run.
- R3: If oof_i[n] drops to 0 for even one cycle before the 28th tick, lof_o[n] stays 0 and the count starts again from zero.
- R4: lof_o[n] goes from 1 to 0 only after 28 consecutive frame ticks at which oof_i[n] is 0, with oof_i[n] at 0 in every cycle of the run.
- R5: While lof_o[n] is 1, a single cycle with oof_i[n] at 1 restarts the clear window.
- R6: Cycles without frame_tick never advance the count, however long oof_i stays at one level.
- R7: Each tributary integrates independently of the others.
- R8: With ais_on_oof_en at 1, ais_req_o[n] is 1 in every cycle in which oof_i[n] is 1 (same cycle in the default combinational mode).
- R9: With ais_on_lof_en at 1, ais_req_o[n] is 1 in every cycle in which lof_o[n] is 1.
- R10: With both enables at 0, ais_req_o is all zeros whatever oof_i and lof_o are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per DS3 frame period |
| oof_i | input | NUM_TRIB (7) | Per-tributary out-of-frame flag |
| ais_on_oof_en | input | 1 | Request alarm insertion while out-of-frame |
| ais_on_lof_en | input | 1 | Request alarm insertion while loss of frame |
| lof_o | output | NUM_TRIB (7) | Per-tributary loss-of-frame flag |
| ais_req_o | output | NUM_TRIB (7) | Per-tributary all-ones insertion request |

## Verification
The assertions assume that frame_tick and oof_i are synchronous to clk and hold steady across each rising edge. Under that assumption, a change of loss-of-frame can only follow a sampled tick with the window counter at its last value. The bench changes every input on the falling edge and keeps ticks single-cycle, with optional idle cycles between them. Runs of 27 and 28 ticks, single-cycle glitches, and long stretches without a tick probe both window edges and the tick gating.

// File: rtl/lofi_pkg.sv
package lofi_pkg;

   typedef enum logic {
      AIS_COMB = 1'b0,
      AIS_REG  = 1'b1
   } ais_timing_e;

   // Width needed to count 0 .. win-1
   function automatic int unsigned win_cnt_width(input int unsigned win);
      return (win <= 2) ? 1 : $clog2(win);
   endfunction

endpackage

// File: rtl/lofi_chan.sv
module lofi_chan #(
   parameter int unsigned WIN = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic oof,
   output logic lof
);
   import lofi_pkg::*;

   localparam int unsigned CW = win_cnt_width(WIN);
   localparam logic [CW-1:0] LAST = CW'(WIN - 1);

   logic [CW-1:0] run_q;
   logic          lof_q;
   logic          disagree;
   logic          window_done;

   assign disagree    = (oof != lof_q);
   assign window_done = disagree && tick && (run_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         lof_q <= 1'b0;
      end else if (!disagree) begin
         run_q <= '0;
      end else if (tick) begin
         if (window_done) begin
            run_q <= '0;
            lof_q <= ~lof_q;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign lof = lof_q;

   // R6
   lof_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lof_q != $past(lof_q)) |-> $past(tick));

   // R2
   lof_set_needs_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lof_q) |-> ($past(oof) && $past(run_q) == LAST));

   // R4
   lof_clear_needs_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lof_q) |-> (!$past(oof) && $past(run_q) == LAST));

   // R3
   run_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LAST);

endmodule

// File: rtl/lofi_ais.sv
module lofi_ais #(
   parameter int unsigned         NUM_TRIB = 7,
   parameter lofi_pkg::ais_timing_e TIMING = lofi_pkg::AIS_COMB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRIB-1:0] oof,
   input  logic [NUM_TRIB-1:0] lof,
   input  logic                en_oof,
   input  logic                en_lof,
   output logic [NUM_TRIB-1:0] ais
);
   import lofi_pkg::*;

   logic [NUM_TRIB-1:0] want;

   assign want = ({NUM_TRIB{en_oof}} & oof) | ({NUM_TRIB{en_lof}} & lof);

   generate
      if (TIMING == AIS_COMB) begin : g_comb
         assign ais = want;

         // R10
         ais_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_oof && !en_lof) |-> (ais == '0));

         // R9
         ais_covers_lof_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_lof |-> ((ais & lof) == lof));

         // R8
         ais_covers_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_oof |-> ((ais & oof) == oof));
      end else begin : g_reg
         logic [NUM_TRIB-1:0] ais_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ais_q <= '0;
            else        ais_q <= want;
         end
         assign ais = ais_q;

         // R10
         ais_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_oof && !en_lof) |=> (ais == '0));

         // R9
         ais_covers_lof_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_lof |=> ((ais & $past(lof)) == $past(lof)));
      end
   endgenerate

endmodule

// File: rtl/ds2_lof_integrator.sv
module ds2_lof_integrator #(
   parameter int unsigned           NUM_TRIB = 7,
   parameter int unsigned           WIN      = 28,
   parameter lofi_pkg::ais_timing_e AIS_TIMING = lofi_pkg::AIS_COMB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_tick,
   input  logic [NUM_TRIB-1:0] oof_i,
   input  logic                ais_on_oof_en,
   input  logic                ais_on_lof_en,
   output logic [NUM_TRIB-1:0] lof_o,
   output logic [NUM_TRIB-1:0] ais_req_o
);

   generate
      if (NUM_TRIB < 1) begin : g_bad_trib
         $error("NUM_TRIB must be at least 1");
      end
      if (WIN < 2) begin : g_bad_win
         $error("WIN must be at least 2");
      end
   endgenerate

   logic [NUM_TRIB-1:0] lof_w;

   for (genvar n = 0; n < NUM_TRIB; n++) begin : g_trib
      lofi_chan #(
         .WIN (WIN)
      ) i_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (frame_tick),
         .oof  (oof_i[n]),
         .lof  (lof_w[n])
      );
   end

   lofi_ais #(
      .NUM_TRIB(NUM_TRIB),
      .TIMING  (AIS_TIMING)
   ) i_ais (
      .clk   (clk),
      .rst_n (rst_n),
      .oof   (oof_i),
      .lof   (lof_w),
      .en_oof(ais_on_oof_en),
      .en_lof(ais_on_lof_en),
      .ais   (ais_req_o)
   );

   assign lof_o = lof_w;

   // R1
   lof_clear_after_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (lof_o == '0));

endmodule

// File: tb/test_ds2_lof_integrator.sv
`timescale 1ns/1ps
module test_ds2_lof_integrator;

   localparam int NT  = 7;
   localparam int WIN = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_tick = 1'b0;
   logic [NT-1:0] oof_i = '0;
   logic          ais_on_oof_en = 1'b0;
   logic          ais_on_lof_en = 1'b0;
   logic [NT-1:0] lof_o;
   logic [NT-1:0] ais_req_o;

   always #2 clk = ~clk;

   ds2_lof_integrator i_ds2_lof_integrator (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .oof_i(oof_i),
      .ais_on_oof_en(ais_on_oof_en), .ais_on_lof_en(ais_on_lof_en),
      .lof_o(lof_o), .ais_req_o(ais_req_o)
   );

   typedef struct {
      logic [NT-1:0] lof;
      logic [NT-1:0] ais;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // Requirement-level model: a run counter per tributary
   int   m_run [NT];
   logic [NT-1:0] m_lof = '0;

   task automatic drive(input logic tk, input logic [NT-1:0] v,
                        input logic eo, input logic el, input string tag);
      exp_t e;
      @(negedge clk);
      frame_tick = tk; oof_i = v; ais_on_oof_en = eo; ais_on_lof_en = el;
      for (int n = 0; n < NT; n++) begin
         if (v[n] == m_lof[n]) m_run[n] = 0;
         else if (tk) begin
            m_run[n]++;
            if (m_run[n] == WIN) begin
               m_run[n] = 0;
               m_lof[n] = ~m_lof[n];
            end
         end
      end
      e.lof = m_lof;
      e.ais = ({NT{eo}} & v) | ({NT{el}} & m_lof);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic ticks(input int cnt, input int gap, input logic [NT-1:0] v,
                        input logic eo, input logic el, input string tag);
      for (int k = 0; k < cnt; k++) begin
         drive(1'b1, v, eo, el, tag);
         for (int g = 0; g < gap; g++) drive(1'b0, v, eo, el, tag);
      end
   endtask

   // Monitor: compares once outputs settle after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (lof_o !== e.lof || ais_req_o !== e.ais) begin
               n_bad++;
               $display("FAIL %s: lof=%b ais=%b expected lof=%b ais=%b",
                        e.tag, lof_o, ais_req_o, e.lof, e.ais);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < NT; n++) m_run[n] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (lof_o !== '0 || ais_req_o !== '0) begin
         n_bad++;
         $display("FAIL R1: lof=%b ais=%b expected lof=0 ais=0", lof_o, ais_req_o);
      end

      // R3: 27 ticks high, one low cycle restarts the window
      ticks(27, 1, 7'h01, 1'b0, 1'b0, "R3");
      drive(1'b0, 7'h00, 1'b0, 1'b0, "R3");
      // R2: full 28-tick run sets lof on channel 0
      ticks(28, 1, 7'h01, 1'b0, 1'b0, "R2");
      // R6: long stretch of channel 1 high with no tick
      for (int k = 0; k < 40; k++) drive(1'b0, 7'h03, 1'b0, 1'b0, "R6");
      drive(1'b0, 7'h01, 1'b0, 1'b0, "R6");
      // R5: a glitch high during the clear window restarts it
      ticks(20, 0, 7'h00, 1'b0, 1'b0, "R5");
      drive(1'b0, 7'h01, 1'b0, 1'b0, "R5");
      // R4: full low run clears lof
      ticks(27, 0, 7'h00, 1'b0, 1'b0, "R4");
      ticks(1, 0, 7'h00, 1'b0, 1'b0, "R4");
      ticks(2, 0, 7'h00, 1'b0, 1'b0, "R4");
      // R7: channel 1 steady high, channel 2 toggling every 10 ticks
      for (int k = 0; k < 30; k++) begin
         logic [NT-1:0] v;
         v = 7'h02 | (((k / 10) % 2 == 1) ? 7'h04 : 7'h00);
         drive(1'b1, v, 1'b0, 1'b0, "R7");
         drive(1'b0, v, 1'b0, 1'b0, "R7");
      end
      // R8..R10: channel 1 in LOF, channel 3 out of frame
      for (int k = 0; k < 4; k++) drive(1'b0, 7'h0A, 1'b1, 1'b0, "R8");
      for (int k = 0; k < 4; k++) drive(1'b0, 7'h08, 1'b0, 1'b1, "R9");
      for (int k = 0; k < 4; k++) drive(1'b0, 7'h7F, 1'b0, 1'b0, "R10");
      for (int k = 0; k < 4; k++) drive(1'b0, 7'h08, 1'b1, 1'b1, "R8");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule